// File: doc/BRIEF.md
# Link Health Status and Indicator Controller

This block reports the health of one end of a fiber link extender. A two-bit status code tells the attached host what the module has reached: powered only, logic configured but no usable incoming link, or incoming link working. The code 00 is never driven. That value is left to mean "no power", which a host sees through bias resistors when the module is dead.

The block also drives two front-panel LEDs. The link-error LED stretches each receive-error or loss-of-signal pulse, even one that lasts a single word, into a pulse long enough to see. The heartbeat LED blinks at a fixed rate once configuration has finished. When the protect-mode strap is set, the two LED outputs trade roles, so the operator can tell which boot image is running.

The link is declared working only after a parameterised run of consecutive error-free received words. Any error sends the code back to the configured-but-no-link value.

Top module: `link_health_ctrl`

## Requirements
- R1: While rst_ni is low, status_o is 2'b11 and both LED outputs are 0.
- R2: status_o never takes the value 2'b00 outside reset.
- R3: status_o moves from 2'b11 to 2'b01 one clock after cfg_done_i is first seen high. Whenever cfg_done_i is sampled low, status_o is 2'b11 on the next cycle.
- R4: With status_o at 2'b01, status_o becomes 2'b10 on the clock that samples the GOOD_WORDS-th consecutive word with word_vld_i=1 and rx_err_i=0.
- R5: A cycle with rx_err_i=1 while configured makes status_o 2'b01 on the next cycle, from either 2'b01 or 2'b10. It also restarts the error-free word count from zero. Cycles with word_vld_i=0 and rx_err_i=0 leave the count unchanged.
- R6: After a cycle with rx_err_i=1, the link-error indication is 1 for exactly STRETCH_CYC cycles and then returns to 0.
- R7: An error that arrives while the indication is already lit restarts the full STRETCH_CYC interval.
- R8: Once configured, the heartbeat indication alternates high and low every BEAT_HALF_CYC cycles. While status_o is 2'b11 it is held at 0.
- R9: With protect_i=0, err_led_o carries the link-error indication and beat_led_o carries the heartbeat. With protect_i=1 the two are exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_done_i | input | 1 | Logic configuration complete |
| word_vld_i | input | 1 | One received word per cycle when high |
| rx_err_i | input | 1 | Receive error or loss of signal for the current word |
| protect_i | input | 1 | Protect-mode strap; swaps the LED roles |
| status_o | output | 2 | Health code: 11 powered, 01 configured, 10 link working |
| err_led_o | output | 1 | Link-error LED (heartbeat when protect_i=1) |
| beat_led_o | output | 1 | Heartbeat LED (link-error when protect_i=1) |

## Verification
Two functions can act in the same cycle. The status sequencer can be counting toward link-up while the error stretcher is still lit from an earlier error, and a fresh error can land both on a running stretch and on a partial good-word count. The stimulus table places an error in the middle of a good-word run and a second error inside a live stretch. It then checks, cycle by cycle, that the status falls back and has to count the whole run again, and that the LED stays lit for a full new interval measured from the second error. A further test raises the protect strap while the heartbeat runs and an error arrives, and checks that each LED pin carries the other function.

// File: rtl/lhs_pkg.sv
package lhs_pkg;
  typedef enum logic [1:0] {
    ST_PWR  = 2'b11,
    ST_CFG  = 2'b01,
    ST_LINK = 2'b10
  } lhs_state_e;
endpackage

// File: rtl/lhs_status.sv
module lhs_status
  import lhs_pkg::*;
#(
  parameter int unsigned GOOD_WORDS = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_done_i,
  input  logic       word_vld_i,
  input  logic       rx_err_i,
  output lhs_state_e state_o,
  output logic       cfg_ok_o
);
  localparam int unsigned CW = $clog2(GOOD_WORDS + 1);

  lhs_state_e    state_q;
  logic [CW-1:0] good_q;
  logic          good_word;

  assign good_word = word_vld_i && !rx_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR;
      good_q  <= '0;
    end else if (!cfg_done_i) begin
      state_q <= ST_PWR;
      good_q  <= '0;
    end else begin
      unique case (state_q)
        ST_PWR: begin
          state_q <= ST_CFG;
          good_q  <= '0;
        end
        ST_CFG: begin
          if (rx_err_i) good_q <= '0;
          else if (good_word) begin
            if (good_q == CW'(GOOD_WORDS - 1)) begin
              state_q <= ST_LINK;
              good_q  <= '0;
            end else good_q <= good_q + 1'b1;
          end
        end
        ST_LINK: begin
          if (rx_err_i) begin
            state_q <= ST_CFG;
            good_q  <= '0;
          end
        end
        default: state_q <= ST_PWR;
      endcase
    end
  end

  assign state_o  = state_q;
  assign cfg_ok_o = (state_q != ST_PWR);

  p_never_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'b00);
  p_cfg_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_i |=> state_q == ST_PWR);
  p_err_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_i && rx_err_i && state_q != ST_PWR) |=> state_q == ST_CFG);
  p_link_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LINK && $past(state_q) != ST_LINK)
      |-> $past(word_vld_i && !rx_err_i && cfg_done_i));
endmodule

// File: rtl/lhs_stretch.sv
module lhs_stretch #(
  parameter int unsigned STRETCH_CYC = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic led_o
);
  localparam int unsigned SW = $clog2(STRETCH_CYC + 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (trig_i)      cnt_q <= SW'(STRETCH_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign led_o = (cnt_q != '0);

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> led_o);
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> cnt_q == SW'(STRETCH_CYC));
  p_expire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == SW'(1) && !trig_i) |=> !led_o);
endmodule

// File: rtl/lhs_beat.sv
module lhs_beat #(
  parameter int unsigned BEAT_HALF_CYC = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic led_o
);
  localparam int unsigned BW = $clog2(BEAT_HALF_CYC);

  logic [BW-1:0] cnt_q;
  logic          led_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      led_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      led_q <= 1'b0;
    end else if (cnt_q == BW'(BEAT_HALF_CYC - 1)) begin
      cnt_q <= '0;
      led_q <= ~led_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign led_o = led_q;

  p_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !led_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != BW'(BEAT_HALF_CYC - 1)) |=> $stable(led_o));
endmodule

// File: rtl/link_health_ctrl.sv
module link_health_ctrl
  import lhs_pkg::*;
#(
  parameter int unsigned GOOD_WORDS    = 1024,
  parameter int unsigned STRETCH_CYC   = 2_000_000,
  parameter int unsigned BEAT_HALF_CYC = 10_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_done_i,
  input  logic       word_vld_i,
  input  logic       rx_err_i,
  input  logic       protect_i,
  output logic [1:0] status_o,
  output logic       err_led_o,
  output logic       beat_led_o
);
  lhs_state_e state;
  logic       cfg_ok;
  logic       err_ind;
  logic       beat_ind;

  lhs_status #(.GOOD_WORDS(GOOD_WORDS)) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_done_i (cfg_done_i),
    .word_vld_i (word_vld_i),
    .rx_err_i   (rx_err_i),
    .state_o    (state),
    .cfg_ok_o   (cfg_ok)
  );

  lhs_stretch #(.STRETCH_CYC(STRETCH_CYC)) i_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (rx_err_i),
    .led_o  (err_ind)
  );

  lhs_beat #(.BEAT_HALF_CYC(BEAT_HALF_CYC)) i_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_ok),
    .led_o  (beat_ind)
  );

  assign status_o   = state;
  assign err_led_o  = protect_i ? beat_ind : err_ind;
  assign beat_led_o = protect_i ? err_ind  : beat_ind;

  p_swap_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_i && rx_err_i) |=> (protect_i -> beat_led_o));
  p_normal_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!protect_i && rx_err_i) |=> (!protect_i -> err_led_o));
endmodule

// File: tb/test_link_health_ctrl.sv
module test_link_health_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 4;
  localparam int SC = 5;
  localparam int BH = 6;
  localparam int NV = 20;
  localparam int WD_CYC = 5000;

  // {cfg, vld, err, exp_status[1:0], exp_err_led}
  localparam logic [5:0] VEC [NV] = '{
    6'b000_11_0, 6'b100_01_0, 6'b110_01_0, 6'b110_01_0, 6'b110_01_0,
    6'b111_01_1, 6'b110_01_1, 6'b110_01_1, 6'b110_01_1, 6'b110_10_1,
    6'b100_10_0, 6'b101_01_1, 6'b110_01_1, 6'b101_01_1, 6'b100_01_1,
    6'b100_01_1, 6'b100_01_1, 6'b100_01_1, 6'b100_01_0, 6'b000_11_0
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_done_i = 1'b0, word_vld_i = 1'b0, rx_err_i = 1'b0, protect_i = 1'b0;
  logic [1:0] status_o;
  logic err_led_o, beat_led_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_health_ctrl #(.GOOD_WORDS(GW), .STRETCH_CYC(SC), .BEAT_HALF_CYC(BH))
    i_link_health_ctrl (
      .clk_i(clk), .rst_ni(rst_ni), .cfg_done_i(cfg_done_i),
      .word_vld_i(word_vld_i), .rx_err_i(rx_err_i), .protect_i(protect_i),
      .status_o(status_o), .err_led_o(err_led_o), .beat_led_o(beat_led_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cfg_done_i = 1'b0; word_vld_i = 1'b0; rx_err_i = 1'b0; protect_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi, lo, seen;
    // R1 reset state
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 status", status_o, 3);
    chk("R1 err_led", err_led_o, 0);
    chk("R1 beat_led", beat_led_o, 0);
    rst_ni = 1'b1;

    // vector walk: R3 R4 R5 R6 R7 and R2 each cycle
    for (int i = 0; i < NV; i++) begin
      {cfg_done_i, word_vld_i, rx_err_i} = VEC[i][5:3];
      @(negedge clk);
      chk($sformatf("R3/R4/R5 status vec %0d", i), status_o, int'(VEC[i][2:1]));
      chk($sformatf("R6/R7 err_led vec %0d", i), err_led_o, int'(VEC[i][0]));
      chk($sformatf("R2 nonzero vec %0d", i), int'(status_o != 2'b00), 1);
    end

    // R8 heartbeat: off while unconfigured, then BH high / BH low
    do_reset();
    @(negedge clk);
    chk("R8 off unconfigured", beat_led_o, 0);
    cfg_done_i = 1'b1;
    seen = 0;
    for (int k = 0; k < 50 && !seen; k++) begin
      @(negedge clk);
      if (beat_led_o) seen = 1;
    end
    chk("R8 beat starts", seen, 1);
    hi = 1;
    while (beat_led_o && hi < 40) begin @(negedge clk); if (beat_led_o) hi++; end
    lo = 1;
    while (!beat_led_o && lo < 40) begin @(negedge clk); if (!beat_led_o) lo++; end
    chk("R8 high width", hi, BH);
    chk("R8 low width", lo, BH);
    cfg_done_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 off after deconfig", beat_led_o, 0);
    chk("R3 back to powered", status_o, 3);

    // R9 swap under protect, with error stretch and heartbeat together
    do_reset();
    cfg_done_i = 1'b1;
    protect_i = 1'b1;
    repeat (3) @(negedge clk);
    rx_err_i = 1'b1;
    @(negedge clk);
    rx_err_i = 1'b0;
    chk("R9 beat pin carries error", beat_led_o, 1);
    repeat (SC) @(negedge clk);
    chk("R9 beat pin error expired", beat_led_o, 0);
    hi = 0;
    for (int k = 0; k < 2*BH; k++) begin
      @(negedge clk);
      if (err_led_o) hi++;
    end
    chk("R9 err pin carries heartbeat", hi, BH);
    protect_i = 1'b0;
    rx_err_i = 1'b1;
    @(negedge clk);
    rx_err_i = 1'b0;
    chk("R9 normal err pin", err_led_o, 1);
    chk("R5 status after error", status_o, 1);

    // R1 reset mid-operation
    rst_ni = 1'b0;
    #1;
    chk("R1 async status", status_o, 3);
    chk("R1 async err_led", err_led_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule